// File: doc/BRIEF.md
# Fetch Redirect and Misprediction Unit

This block owns the fetch program counter of a pipelined core. In every cycle it picks the address to fetch next. If the direction predictor and the target buffer together call for a taken transfer, it takes the buffered target. Otherwise it takes the sequential address. The direction decision ORs the counter's direction bit with an is-jump flag stored in the buffer entry, and it only counts when the buffer reports a hit.

On the execute side the block checks each resolved branch or jump against the prediction that travelled with it down the pipe. A wrong direction, or a taken transfer whose predicted target differs from the computed one, is a misprediction. In the same cycle the block pulses flushes for the IF/ID and ID/EX registers and raises update strobes toward the direction table and the target buffer. At the next clock edge it loads the corrected address into the PC, and this correction overrides any fetch-side prediction.

Top module: `fetch_redirect_unit`

## Requirements
- R1: While rst_n is low, fetch_pc_o holds BOOT_ADDR (default 0x0000_1000) and both flush outputs stay low, whatever the execute inputs are.
- R2: fetch_pred_taken_o is (pred_dir_i OR btb_is_jump_i) AND btb_hit_i, combinationally in the same cycle.
- R3: With no misprediction and fetch_pred_taken_o high, next_pc_o equals btb_target_i, and fetch_pc_o takes that value after the next rising edge.
- R4: With no misprediction and fetch_pred_taken_o low (either no predicted transfer or a buffer miss), next_pc_o equals fetch_pc_o + INSTR_BYTES (4).
- R5: The execute stage is checked only when ex_valid_i is high and ex_is_branch_i or ex_is_jump_i is high. Any other instruction never flushes, redirects or raises an update strobe.
- R6: A checked instruction whose ex_pred_taken_i differs from ex_taken_i raises flush_ifid_o and flush_idex_o in the same cycle.
- R7: A checked instruction that was predicted taken and was actually taken, but whose ex_pred_target_i differs from ex_target_i, is a misprediction and flushes as in R6.
- R8: After a misprediction, fetch_pc_o at the next edge becomes ex_target_i if the instruction was taken, or ex_pc_i + 4 if it was not. This overrides the fetch-side choice of that cycle.
- R9: On a misprediction, upd_bht_o is high when ex_is_branch_i is high, and upd_btb_o is high when ex_taken_i is high. Both stay low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_dir_i | input | 1 | Direction bit of the indexed saturating counter |
| btb_hit_i | input | 1 | Target buffer tag hit for fetch_pc_o |
| btb_is_jump_i | input | 1 | Is-jump flag of the hit buffer entry |
| btb_target_i | input | XLEN | Buffered target of the hit entry |
| fetch_pc_o | output | XLEN | Current fetch address (PC register) |
| next_pc_o | output | XLEN | Address the PC loads at the next edge |
| fetch_pred_taken_o | output | 1 | Effective taken prediction, to travel with the instruction |
| fetch_pred_target_o | output | XLEN | Predicted target, to travel with the instruction |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| ex_is_branch_i | input | 1 | Execute instruction is a conditional branch |
| ex_is_jump_i | input | 1 | Execute instruction is a jump |
| ex_pc_i | input | XLEN | PC of the execute instruction |
| ex_pred_taken_i | input | 1 | Taken prediction recorded at fetch |
| ex_pred_target_i | input | XLEN | Target predicted at fetch |
| ex_taken_i | input | 1 | Resolved outcome |
| ex_target_i | input | XLEN | Resolved target address |
| flush_ifid_o | output | 1 | Flush of the IF/ID register |
| flush_idex_o | output | 1 | Flush of the ID/EX register |
| upd_bht_o | output | 1 | Update strobe for the direction table |
| upd_btb_o | output | 1 | Update strobe for the target buffer |

## Verification
Flushes, update strobes, fetch_pred_taken_o and next_pc_o are combinational and due in the cycle their inputs are applied. fetch_pc_o is due one edge later. The driver applies each stimulus on a falling edge and queues one expected item covering both timings. The monitor pops that item 1 ns after the same falling edge. At that moment the combinational results of the new stimulus are settled, and fetch_pc_o shows the value loaded by the preceding rising edge, so the model's PC lags by exactly one stimulus.

// File: rtl/fru_pkg.sv
package fru_pkg;
   // Source of the address loaded into the PC register
   typedef enum logic [1:0] {
      SRC_SEQ  = 2'd0,
      SRC_PRED = 2'd1,
      SRC_FIX  = 2'd2
   } next_src_e;
endpackage

// File: rtl/fru_fetch_select.sv
module fru_fetch_select #(
   parameter int XLEN        = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic            dir_i,
   input  logic            hit_i,
   input  logic            is_jump_i,
   input  logic [XLEN-1:0] target_i,
   output logic            taken_o,
   output logic [XLEN-1:0] seq_pc_o,
   output logic [XLEN-1:0] pred_pc_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   logic want_taken;

   // Counter direction OR entry is-jump; only meaningful with a tag hit
   assign want_taken = dir_i | is_jump_i;
   assign taken_o    = want_taken & hit_i;
   assign seq_pc_o   = pc_i + STEP;
   assign pred_pc_o  = taken_o ? target_i : seq_pc_o;
endmodule

// File: rtl/fru_resolve.sv
module fru_resolve #(
   parameter int XLEN        = 32,
   parameter int INSTR_BYTES = 4,
   parameter bit CMP_TARGET  = 1'b1
) (
   input  logic            valid_i,
   input  logic            is_branch_i,
   input  logic            is_jump_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            pred_taken_i,
   input  logic [XLEN-1:0] pred_target_i,
   input  logic            taken_i,
   input  logic [XLEN-1:0] target_i,
   output logic            mispredict_o,
   output logic [XLEN-1:0] fix_pc_o,
   output logic            upd_bht_o,
   output logic            upd_btb_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   logic checked;
   logic dir_bad;
   logic tgt_bad;

   assign checked = valid_i & (is_branch_i | is_jump_i);
   assign dir_bad = pred_taken_i ^ taken_i;

   generate
      if (CMP_TARGET) begin : g_cmp_target
         assign tgt_bad = taken_i & pred_taken_i & (pred_target_i != target_i);
      end else begin : g_dir_only
         assign tgt_bad = 1'b0;
      end
   endgenerate

   assign mispredict_o = checked & (dir_bad | tgt_bad);
   assign fix_pc_o     = taken_i ? target_i : (pc_i + STEP);
   assign upd_bht_o    = mispredict_o & is_branch_i;
   assign upd_btb_o    = mispredict_o & taken_i;

   always_comb begin
      if (!checked) begin
         assert_unchecked_quiet_R5 : assert (!mispredict_o && !upd_bht_o && !upd_btb_o);
      end
   end
endmodule

// File: rtl/fru_pc_reg.sv
module fru_pc_reg #(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] BOOT_ADDR = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] d_i,
   output logic [XLEN-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= BOOT_ADDR;
      else        q_o <= d_i;
   end
endmodule

// File: rtl/fetch_redirect_unit.sv
module fetch_redirect_unit #(
   parameter int              XLEN        = 32,
   parameter int              INSTR_BYTES = 4,
   parameter bit              CMP_TARGET  = 1'b1,
   parameter logic [XLEN-1:0] BOOT_ADDR   = XLEN'(32'h0000_1000)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pred_dir_i,
   input  logic            btb_hit_i,
   input  logic            btb_is_jump_i,
   input  logic [XLEN-1:0] btb_target_i,
   output logic [XLEN-1:0] fetch_pc_o,
   output logic [XLEN-1:0] next_pc_o,
   output logic            fetch_pred_taken_o,
   output logic [XLEN-1:0] fetch_pred_target_o,
   input  logic            ex_valid_i,
   input  logic            ex_is_branch_i,
   input  logic            ex_is_jump_i,
   input  logic [XLEN-1:0] ex_pc_i,
   input  logic            ex_pred_taken_i,
   input  logic [XLEN-1:0] ex_pred_target_i,
   input  logic            ex_taken_i,
   input  logic [XLEN-1:0] ex_target_i,
   output logic            flush_ifid_o,
   output logic            flush_idex_o,
   output logic            upd_bht_o,
   output logic            upd_btb_o
);
   import fru_pkg::*;

   localparam int ALIGN_MASK = INSTR_BYTES - 1;

   generate
      if (XLEN < 8 || XLEN > 64) begin : g_bad_xlen
         $error("fetch_redirect_unit: XLEN out of range");
      end
      if (INSTR_BYTES < 1 || (INSTR_BYTES & ALIGN_MASK) != 0) begin : g_bad_step
         $error("fetch_redirect_unit: INSTR_BYTES must be a power of two");
      end
      if ((int'(BOOT_ADDR) & ALIGN_MASK) != 0) begin : g_bad_boot
         $error("fetch_redirect_unit: BOOT_ADDR not aligned");
      end
   endgenerate

   logic            pred_taken;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] pred_pc;
   logic            mispredict;
   logic [XLEN-1:0] fix_pc;
   logic            upd_bht;
   logic            upd_btb;
   next_src_e       src;
   logic [XLEN-1:0] pc_d;

   fru_fetch_select #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_select (
      .pc_i      (fetch_pc_o),
      .dir_i     (pred_dir_i),
      .hit_i     (btb_hit_i),
      .is_jump_i (btb_is_jump_i),
      .target_i  (btb_target_i),
      .taken_o   (pred_taken),
      .seq_pc_o  (seq_pc),
      .pred_pc_o (pred_pc)
   );

   fru_resolve #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES), .CMP_TARGET(CMP_TARGET)) u_resolve (
      .valid_i       (ex_valid_i),
      .is_branch_i   (ex_is_branch_i),
      .is_jump_i     (ex_is_jump_i),
      .pc_i          (ex_pc_i),
      .pred_taken_i  (ex_pred_taken_i),
      .pred_target_i (ex_pred_target_i),
      .taken_i       (ex_taken_i),
      .target_i      (ex_target_i),
      .mispredict_o  (mispredict),
      .fix_pc_o      (fix_pc),
      .upd_bht_o     (upd_bht),
      .upd_btb_o     (upd_btb)
   );

   // Execute redirect wins over the fetch-side prediction
   always_comb begin
      if (mispredict)      src = SRC_FIX;
      else if (pred_taken) src = SRC_PRED;
      else                 src = SRC_SEQ;
   end

   always_comb begin
      unique case (src)
         SRC_FIX:  pc_d = fix_pc;
         SRC_PRED: pc_d = pred_pc;
         SRC_SEQ:  pc_d = seq_pc;
         default:  pc_d = seq_pc;
      endcase
   end

   fru_pc_reg #(.XLEN(XLEN), .BOOT_ADDR(BOOT_ADDR)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pc_d),
      .q_o   (fetch_pc_o)
   );

   assign next_pc_o           = pc_d;
   assign fetch_pred_taken_o  = pred_taken;
   assign fetch_pred_target_o = btb_target_i;
   assign flush_ifid_o        = rst_n & mispredict;
   assign flush_idex_o        = rst_n & mispredict;
   assign upd_bht_o           = rst_n & upd_bht;
   assign upd_btb_o           = rst_n & upd_btb;

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1 : assert (!flush_ifid_o && !flush_idex_o);
      end
   end

   assert_redirect_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> fetch_pc_o == $past(fix_pc));

   assert_follow_pred_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!mispredict && fetch_pred_taken_o) |=> fetch_pc_o == $past(btb_target_i));

   assert_sequential_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!mispredict && !fetch_pred_taken_o) |=>
         fetch_pc_o == $past(fetch_pc_o) + XLEN'(INSTR_BYTES));

   assert_flush_pair_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid_i && (ex_is_branch_i || ex_is_jump_i) && (ex_pred_taken_i != ex_taken_i))
         |-> (flush_ifid_o && flush_idex_o));

   assert_no_check_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_valid_i && (ex_is_branch_i || ex_is_jump_i)) |-> !flush_ifid_o && !upd_btb_o);
endmodule

// File: tb/fetch_redirect_unit_bench.sv
module fetch_redirect_unit_bench;
   localparam int          XLEN = 32;
   localparam logic [31:0] BOOT = 32'h0000_1000;

   typedef struct {
      string       tag;
      logic [31:0] pc;
      logic        taken;
      logic [31:0] nxt;
      logic        flush;
      logic        ubht;
      logic        ubtb;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pred_dir = 0, btb_hit = 0, btb_jmp = 0;
   logic [31:0] btb_tgt = '0;
   logic        ex_v = 0, ex_br = 0, ex_jp = 0, ex_pt = 0, ex_t = 0;
   logic [31:0] ex_pc = '0, ex_ptg = '0, ex_tg = '0;
   logic [31:0] fetch_pc, next_pc, pred_tgt;
   logic        pred_taken, fl_ifid, fl_idex, upd_bht, upd_btb;

   int    checks = 0;
   int    fails = 0;
   bit    done = 0;
   item_t sb_q[$];
   logic [31:0] model_pc;

   always #2 clk = ~clk;

   fetch_redirect_unit #(.XLEN(XLEN), .BOOT_ADDR(BOOT)) u_fetch_redirect_unit (
      .clk(clk), .rst_n(rst_n),
      .pred_dir_i(pred_dir), .btb_hit_i(btb_hit), .btb_is_jump_i(btb_jmp),
      .btb_target_i(btb_tgt), .fetch_pc_o(fetch_pc), .next_pc_o(next_pc),
      .fetch_pred_taken_o(pred_taken), .fetch_pred_target_o(pred_tgt),
      .ex_valid_i(ex_v), .ex_is_branch_i(ex_br), .ex_is_jump_i(ex_jp),
      .ex_pc_i(ex_pc), .ex_pred_taken_i(ex_pt), .ex_pred_target_i(ex_ptg),
      .ex_taken_i(ex_t), .ex_target_i(ex_tg),
      .flush_ifid_o(fl_ifid), .flush_idex_o(fl_idex),
      .upd_bht_o(upd_bht), .upd_btb_o(upd_btb)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Drive one cycle of stimulus on the current falling edge and queue its expectation
   task automatic step(string tag, logic d, logic h, logic j, logic [31:0] bt,
                       logic v, logic br, logic jp, logic [31:0] epc, logic pt,
                       logic [31:0] ptg, logic t, logic [31:0] tg);
      item_t it;
      logic  tk, chk, mis;
      pred_dir = d; btb_hit = h; btb_jmp = j; btb_tgt = bt;
      ex_v = v; ex_br = br; ex_jp = jp; ex_pc = epc;
      ex_pt = pt; ex_ptg = ptg; ex_t = t; ex_tg = tg;
      tk  = (d | j) & h;
      chk = v & (br | jp);
      mis = chk & ((pt != t) | (t & pt & (ptg != tg)));
      it.tag   = tag;
      it.pc    = model_pc;
      it.taken = tk;
      it.flush = mis;
      it.ubht  = mis & br;
      it.ubtb  = mis & t;
      if (mis)     it.nxt = t ? tg : epc + 32'd4;
      else if (tk) it.nxt = bt;
      else         it.nxt = model_pc + 32'd4;
      sb_q.push_back(it);
      model_pc = it.nxt;
      @(negedge clk);
   endtask

   // Monitor: compares each queued item 1 ns after its falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, "fetch_pc", fetch_pc, it.pc);
            check({it.tag, "/R2"}, "pred_taken", 32'(pred_taken), 32'(it.taken));
            check(it.tag, "next_pc", next_pc, it.nxt);
            check({it.tag, "/R6"}, "flush_ifid", 32'(fl_ifid), 32'(it.flush));
            check({it.tag, "/R6"}, "flush_idex", 32'(fl_idex), 32'(it.flush));
            check({it.tag, "/R9"}, "upd_bht", 32'(upd_bht), 32'(it.ubht));
            check({it.tag, "/R9"}, "upd_btb", 32'(upd_btb), 32'(it.ubtb));
         end
      end
   end

   initial begin
      #20000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_pc = BOOT;
      // R1: mismatching branch at execute while reset is held
      @(negedge clk);
      ex_v = 1; ex_br = 1; ex_pt = 0; ex_t = 1; ex_tg = 32'h5000;
      #1;
      check("R1", "fetch_pc", fetch_pc, BOOT);
      check("R1", "flush_ifid", 32'(fl_ifid), 32'd0);
      check("R1", "flush_idex", 32'(fl_idex), 32'd0);
      @(negedge clk);
      #1;
      check("R1", "fetch_pc after edge", fetch_pc, BOOT);
      @(negedge clk);
      rst_n = 1'b1;
      // fetch-side choices
      step("R4 idle",         0, 0, 0, 32'h0,    0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      step("R3 dir hit",      1, 1, 0, 32'h2000, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      step("R3 jump flag",    0, 1, 1, 32'h3000, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      step("R4 dir miss",     1, 0, 0, 32'h7000, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      step("R4 jump miss",    0, 0, 1, 32'h7100, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      step("R4 hit not tkn",  0, 1, 0, 32'h7200, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      // execute-side checking
      step("R5 plain instr",  0, 0, 0, 32'h0,    1, 0, 0, 32'h4000, 0, 32'h0, 1, 32'h9000);
      step("R5 not valid",    0, 0, 0, 32'h0,    0, 1, 0, 32'h4000, 0, 32'h0, 1, 32'h9000);
      step("R8 NT->T prio",   1, 1, 0, 32'h2000, 1, 1, 0, 32'h4000, 0, 32'h0, 1, 32'h5000);
      step("R8 T->NT",        0, 0, 0, 32'h0,    1, 1, 0, 32'h4000, 1, 32'h6000, 0, 32'h6000);
      step("R7 jump tgt",     0, 1, 1, 32'h3000, 1, 0, 1, 32'h4800, 1, 32'h6000, 1, 32'h6100);
      step("R7 branch tgt",   0, 0, 0, 32'h0,    1, 1, 0, 32'h4900, 1, 32'h6000, 1, 32'h6200);
      step("R6 good taken",   0, 0, 0, 32'h0,    1, 1, 0, 32'h4a00, 1, 32'h6000, 1, 32'h6000);
      step("R6 good not tkn", 0, 0, 0, 32'h0,    1, 1, 0, 32'h4b00, 0, 32'h0,   0, 32'h0);
      step("R9 jump NT->T",   0, 0, 0, 32'h0,    1, 0, 1, 32'h4c00, 0, 32'h0,   1, 32'h8000);
      step("R3 after fix",    1, 1, 0, 32'ha000, 0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      step("R4 final",        0, 0, 0, 32'h0,    0, 0, 0, 32'h0, 0, 32'h0, 0, 32'h0);
      @(negedge clk);
      @(negedge clk);
      check("queue", "left", 32'(sb_q.size()), 32'd0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule